// File: doc/BRIEF.md
# I2C Controller Byte FIFOs with Threshold Events

This block holds the transmit and receive byte queues of an I2C controller. Software writes bytes into the transmit queue and reads bytes out of the receive queue through a single data port. The bus engine takes transmit bytes from one side and deposits received bytes on the other. A configuration word sets one threshold per queue and can empty either queue.

A transfer length is loaded before each transfer. A counter of the bytes still to move on the bus is decremented by every bus-side strobe. From the queue levels, the thresholds and that counter, the block raises four single-cycle events. Two are "ready" events that ask software to service a full threshold's worth of bytes. Two are "draining" events that ask software to handle the final partial batch, which can never reach the threshold.

The queue depth is a parameter given as a code n, where depth = 8 << n bytes. The code is reported on an output.

Top module: `i2c_fifo_events`

## Requirements
- R1: After reset both levels read 0, all four events are low, `depth_code` equals the DEPTH_CODE parameter and both data outputs read 0.
- R2: A `data_wr` strobe appends `data_wdata` to the transmit queue. When the queue already holds depth bytes the write is dropped and the stored contents are unchanged.
- R3: Bytes leave each queue in arrival order. `rx_push` appends `rx_byte`. `data_rdata` shows the oldest receive byte, and `data_rd` removes it. `tx_byte` shows the oldest transmit byte, and `tx_pop` removes it. An empty queue shows 0.
- R4: On a `cfg_wr` strobe, bit 6 set empties the transmit queue and bit 14 set empties the receive queue. A flush takes precedence over a push in the same cycle.
- R5: The receive threshold is `cfg_val[13:8]` + 1. `rx_ready_evt` is high for exactly one cycle when the receive level rises from below the threshold to at or above it.
- R6: `rx_drain_evt` is high for one cycle when the bytes-left counter is 0, the receive level is non-zero and the receive level is below the receive threshold. It requires that the last length load was non-zero.
- R7: The transmit threshold is `cfg_val[5:0]` + 1. Let supply = bytes-left minus transmit level, floored at 0. `tx_ready_evt` is high for one cycle when "transmit level below threshold and supply at least the threshold" becomes true.
- R8: `tx_drain_evt` is high for one cycle when "transmit level below threshold and 0 < supply < threshold" becomes true. It is never high in the same cycle as `tx_ready_evt`.
- R9: A `len_wr` strobe loads the 16-bit bytes-left counter. Each `rx_push` or `tx_pop` strobe decrements it, stopping at 0 rather than wrapping. A zero-length load marks no valid transfer and suppresses both draining events and `tx_ready_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Load the transfer length |
| len_val | input | 16 | Transfer length in bytes |
| cfg_wr | input | 1 | Write the buffer configuration word |
| cfg_val | input | 16 | Thresholds minus one ([5:0] tx, [13:8] rx); flush bits 6 (tx) and 14 (rx) |
| data_wr | input | 1 | Software push into the transmit queue |
| data_wdata | input | 8 | Byte to push |
| data_rd | input | 1 | Software pop from the receive queue |
| data_rdata | output | 8 | Oldest receive byte, 0 when empty |
| rx_push | input | 1 | Bus engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Bus engine consumes a transmit byte |
| tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| tx_level | output | DEPTH_CODE+4 | Transmit queue level |
| rx_level | output | DEPTH_CODE+4 | Receive queue level |
| depth_code | output | 2 | Depth code n, depth = 8 << n |
| rx_ready_evt | output | 1 | Receive threshold reached |
| rx_drain_evt | output | 1 | Final partial receive batch available |
| tx_ready_evt | output | 1 | Room for a threshold's worth of transmit bytes |
| tx_drain_evt | output | 1 | Room for the final partial transmit batch |

## Verification
Each queue has its own pointer and level state. A corrupted pointer or level appears at once on `tx_level`/`rx_level`, and it appears on the next pop as a byte out of order on `tx_byte`/`data_rdata`. A wrong bytes-left count is only visible through the events. It shows as a draining event that is missing, extra or a cycle late around the final bytes of a transfer, and the saturation and zero-length cases target exactly that. Edge-detector state that sticks shows as an event held for more than one cycle, or as a second pulse without a new crossing.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
   localparam int CFG_TX_THR_LSB = 0;
   localparam int CFG_TX_FLUSH   = 6;
   localparam int CFG_RX_THR_LSB = 8;
   localparam int CFG_RX_FLUSH   = 14;
   localparam int THR_W          = 6;
   localparam int NUM_EVT        = 4;

   typedef enum int {
      EV_RX_RDY = 0,
      EV_RX_DRN = 1,
      EV_TX_RDY = 2,
      EV_TX_DRN = 3
   } evt_idx_e;

   typedef struct packed {
      logic [THR_W-1:0] tx_m1;
      logic             tx_flush;
      logic [THR_W-1:0] rx_m1;
      logic             rx_flush;
   } cfg_fields_t;

   function automatic cfg_fields_t split_cfg(input logic [15:0] v);
      cfg_fields_t f;
      f.tx_m1    = v[CFG_TX_THR_LSB +: THR_W];
      f.tx_flush = v[CFG_TX_FLUSH];
      f.rx_m1    = v[CFG_RX_THR_LSB +: THR_W];
      f.rx_flush = v[CFG_RX_FLUSH];
      return f;
   endfunction

   function automatic logic [16:0] supply_left(input logic [15:0] rem, input logic [16:0] lvl);
      logic [16:0] r;
      r = {1'b0, rem};
      return (r > lvl) ? (r - lvl) : 17'd0;
   endfunction
endpackage

// File: rtl/i2cfe_byte_fifo.sv
module i2cfe_byte_fifo #(
   parameter int DEPTH_CODE = 1,
   localparam int DEPTH = 8 << DEPTH_CODE,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [7:0]    wdata,
   input  logic          pop,
   output logic [7:0]    head,
   output logic [LW-1:0] level
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          wr_ok, rd_ok;

   assign wr_ok = push && (level != LW'(DEPTH));
   assign rd_ok = pop && (level != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok && !flush) mem[wptr] <= wdata;
   end

   assign head = (level == '0) ? 8'h00 : mem[rptr];
endmodule

// File: rtl/i2cfe_xfer_count.sv
module i2cfe_xfer_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] remaining,
   output logic             valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
         valid     <= 1'b0;
      end else if (load) begin
         remaining <= load_val;
         valid     <= (load_val != '0);
      end else if (dec && remaining != '0) begin
         remaining <= remaining - 1'b1;
      end
   end
endmodule

// File: rtl/i2cfe_evt_edge.sv
module i2cfe_evt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic pulse
);
   logic cond_q;
   always_ff @(posedge clk) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end
   assign pulse = cond && !cond_q;
endmodule

// File: rtl/i2c_fifo_events.sv
module i2c_fifo_events
   import i2cfe_pkg::*;
#(
   parameter int DEPTH_CODE = 1,
   localparam int DEPTH = 8 << DEPTH_CODE,
   localparam int LW    = DEPTH_CODE + 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          len_wr,
   input  logic [15:0]   len_val,
   input  logic          cfg_wr,
   input  logic [15:0]   cfg_val,
   input  logic          data_wr,
   input  logic [7:0]    data_wdata,
   input  logic          data_rd,
   output logic [7:0]    data_rdata,
   input  logic          rx_push,
   input  logic [7:0]    rx_byte,
   input  logic          tx_pop,
   output logic [7:0]    tx_byte,
   output logic [LW-1:0] tx_level,
   output logic [LW-1:0] rx_level,
   output logic [1:0]    depth_code,
   output logic          rx_ready_evt,
   output logic          rx_drain_evt,
   output logic          tx_ready_evt,
   output logic          tx_drain_evt
);
   generate
      if (DEPTH_CODE < 0 || DEPTH_CODE > 3) begin : g_bad_depth
         $error("DEPTH_CODE must lie in 0..3");
      end
   endgenerate

   cfg_fields_t      cfg_in;
   logic [THR_W-1:0] tx_m1_q, rx_m1_q;
   logic [THR_W:0]   tx_thr, rx_thr;
   logic             tx_flush, rx_flush;
   logic [15:0]      remaining;
   logic             xfer_valid;
   logic [16:0]      supply, tx_lvl17, rx_lvl17;
   logic             tx_below;
   logic [NUM_EVT-1:0] cond, evt;
   logic             unused_cfg;

   assign cfg_in     = split_cfg(cfg_val);
   assign unused_cfg = ^{cfg_val[15], cfg_val[7]};
   assign tx_flush   = cfg_wr && cfg_in.tx_flush;
   assign rx_flush   = cfg_wr && cfg_in.rx_flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_m1_q <= '0;
         rx_m1_q <= '0;
      end else if (cfg_wr) begin
         tx_m1_q <= cfg_in.tx_m1;
         rx_m1_q <= cfg_in.rx_m1;
      end
   end

   assign tx_thr = {1'b0, tx_m1_q} + 1'b1;
   assign rx_thr = {1'b0, rx_m1_q} + 1'b1;

   i2cfe_byte_fifo #(.DEPTH_CODE(DEPTH_CODE)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(data_wr), .wdata(data_wdata),
      .pop(tx_pop), .head(tx_byte), .level(tx_level));

   i2cfe_byte_fifo #(.DEPTH_CODE(DEPTH_CODE)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push), .wdata(rx_byte),
      .pop(data_rd), .head(data_rdata), .level(rx_level));

   i2cfe_xfer_count #(.CNT_W(16)) u_left (
      .clk(clk), .rst_n(rst_n), .load(len_wr), .load_val(len_val),
      .dec(rx_push || tx_pop), .remaining(remaining), .valid(xfer_valid));

   assign tx_lvl17 = 17'(tx_level);
   assign rx_lvl17 = 17'(rx_level);
   assign supply   = supply_left(remaining, tx_lvl17);
   assign tx_below = tx_lvl17 < 17'(tx_thr);

   always_comb begin
      cond            = '0;
      cond[EV_RX_RDY] = rx_lvl17 >= 17'(rx_thr);
      cond[EV_RX_DRN] = xfer_valid && (remaining == '0) && (rx_level != '0)
                        && (rx_lvl17 < 17'(rx_thr));
      cond[EV_TX_RDY] = xfer_valid && tx_below && (supply >= 17'(tx_thr));
      cond[EV_TX_DRN] = xfer_valid && tx_below && (supply != '0)
                        && (supply < 17'(tx_thr));
   end

   generate
      for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
         i2cfe_evt_edge u_edge (.clk(clk), .rst_n(rst_n), .cond(cond[g]), .pulse(evt[g]));
      end
   endgenerate

   assign rx_ready_evt = evt[EV_RX_RDY];
   assign rx_drain_evt = evt[EV_RX_DRN];
   assign tx_ready_evt = evt[EV_TX_RDY];
   assign tx_drain_evt = evt[EV_TX_DRN];
   assign depth_code   = 2'(DEPTH_CODE);
endmodule

// File: rtl/i2c_fifo_events_chk.sv
module i2c_fifo_events_chk #(
   parameter int DEPTH_CODE = 1,
   localparam int DEPTH = 8 << DEPTH_CODE,
   localparam int LW    = DEPTH_CODE + 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr,
   input logic [15:0]   cfg_val,
   input logic          data_wr,
   input logic          data_rd,
   input logic          rx_push,
   input logic          tx_pop,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          rx_ready_evt,
   input logic          rx_drain_evt,
   input logic          tx_ready_evt,
   input logic          tx_drain_evt
);
   assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH));

   assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == LW'(DEPTH) && data_wr && !tx_pop && !(cfg_wr && cfg_val[6]))
      |=> tx_level == LW'(DEPTH));

   assert_rx_push_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !data_rd && rx_level < LW'(DEPTH) && !(cfg_wr && cfg_val[14]))
      |=> rx_level == $past(rx_level) + 1'b1);

   assert_tx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_val[6]) |=> tx_level == '0);

   assert_rx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_val[14]) |=> rx_level == '0);

   assert_rx_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready_evt |=> !rx_ready_evt);

   assert_rx_drain_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drain_evt |-> rx_level != '0);

   assert_tx_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_evt |=> !tx_ready_evt);

   assert_tx_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ready_evt && tx_drain_evt));
endmodule

bind i2c_fifo_events i2c_fifo_events_chk #(.DEPTH_CODE(DEPTH_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
   .data_wr(data_wr), .data_rd(data_rd), .rx_push(rx_push), .tx_pop(tx_pop),
   .tx_level(tx_level), .rx_level(rx_level),
   .rx_ready_evt(rx_ready_evt), .rx_drain_evt(rx_drain_evt),
   .tx_ready_evt(tx_ready_evt), .tx_drain_evt(tx_drain_evt));

// File: tb/test_i2c_fifo_events.sv
`timescale 1ns/1ps
module test_i2c_fifo_events;
   localparam int DEPTH_CODE = 1;
   localparam int DEPTH = 8 << DEPTH_CODE;
   localparam int LW = DEPTH_CODE + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic len_wr = 0, cfg_wr = 0, data_wr = 0, data_rd = 0, rx_push = 0, tx_pop = 0;
   logic [15:0] len_val = 0, cfg_val = 0;
   logic [7:0]  data_wdata = 0, rx_byte = 0;
   logic [7:0]  data_rdata, tx_byte;
   logic [LW-1:0] tx_level, rx_level;
   logic [1:0] depth_code;
   logic rx_ready_evt, rx_drain_evt, tx_ready_evt, tx_drain_evt;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   i2c_fifo_events #(.DEPTH_CODE(DEPTH_CODE)) i_i2c_fifo_events (
      .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
      .cfg_wr(cfg_wr), .cfg_val(cfg_val), .data_wr(data_wr), .data_wdata(data_wdata),
      .data_rd(data_rd), .data_rdata(data_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
      .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_level(tx_level), .rx_level(rx_level),
      .depth_code(depth_code), .rx_ready_evt(rx_ready_evt), .rx_drain_evt(rx_drain_evt),
      .tx_ready_evt(tx_ready_evt), .tx_drain_evt(tx_drain_evt));

   // Vector fields: kind[27:26] (0 sw write, 1 bus rx, 2 bus tx pop, 3 sw read),
   // data[25:18], tx level after[17:13], rx level after[12:8], byte seen before op[7:0]
   localparam logic [27:0] VEC [8] = '{
      {2'd0, 8'hA1, 5'd1, 5'd0, 8'h00},
      {2'd0, 8'hB2, 5'd2, 5'd0, 8'h00},
      {2'd1, 8'h5C, 5'd2, 5'd1, 8'h00},
      {2'd1, 8'h6D, 5'd2, 5'd2, 8'h00},
      {2'd2, 8'h00, 5'd1, 5'd2, 8'hA1},
      {2'd3, 8'h00, 5'd1, 5'd1, 8'h5C},
      {2'd2, 8'h00, 5'd0, 5'd1, 8'hB2},
      {2'd3, 8'h00, 5'd0, 5'd0, 8'h6D}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic sw_wr(input logic [7:0] b);
      data_wr = 1; data_wdata = b; tick(); data_wr = 0;
   endtask
   task automatic sw_rd();
      data_rd = 1; tick(); data_rd = 0;
   endtask
   task automatic bus_rx(input logic [7:0] b);
      rx_push = 1; rx_byte = b; tick(); rx_push = 0;
   endtask
   task automatic bus_pop();
      tx_pop = 1; tick(); tx_pop = 0;
   endtask
   task automatic cfg(input logic [15:0] v);
      cfg_wr = 1; cfg_val = v; tick(); cfg_wr = 0;
   endtask
   task automatic load(input logic [15:0] n);
      len_wr = 1; len_val = n; tick(); len_wr = 0;
   endtask

   initial begin
      #(4 * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1;
      // R1 reset state
      chk("R1 tx_level", int'(tx_level), 0);
      chk("R1 rx_level", int'(rx_level), 0);
      chk("R1 events", int'({rx_ready_evt, rx_drain_evt, tx_ready_evt, tx_drain_evt}), 0);
      chk("R1 depth_code", int'(depth_code), DEPTH_CODE);
      chk("R1 data outputs", int'({tx_byte, data_rdata}), 0);

      // thresholds tx 4, rx 3, flush both
      cfg(16'h4243);
      load(16'd1000);

      // R3 order through the vector table
      foreach (VEC[i]) begin
         logic [27:0] v;
         v = VEC[i];
         case (v[27:26])
            2'd0: sw_wr(v[25:18]);
            2'd1: bus_rx(v[25:18]);
            2'd2: begin chk("R3 tx_byte order", int'(tx_byte), int'(v[7:0])); bus_pop(); end
            default: begin chk("R3 rx data order", int'(data_rdata), int'(v[7:0])); sw_rd(); end
         endcase
         chk("R3 tx_level", int'(tx_level), int'(v[17:13]));
         chk("R3 rx_level", int'(rx_level), int'(v[12:8]));
      end

      // R2 write into a full transmit queue is dropped
      for (int i = 0; i <= DEPTH; i++) sw_wr(8'(8'h10 + i));
      chk("R2 full level", int'(tx_level), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R2 drained byte", int'(tx_byte), 8'h10 + i);
         bus_pop();
      end
      chk("R2 empty after drain", int'(tx_level), 0);
      chk("R3 empty tx_byte is 0", int'(tx_byte), 0);

      // R4 flushes
      sw_wr(8'h01); sw_wr(8'h02);
      bus_rx(8'h03); bus_rx(8'h04);
      cfg(16'h0243);
      chk("R4 tx flushed", int'(tx_level), 0);
      chk("R4 rx kept", int'(rx_level), 2);
      cfg(16'h4203);
      chk("R4 rx flushed", int'(rx_level), 0);
      data_wr = 1; data_wdata = 8'h77; cfg_wr = 1; cfg_val = 16'h0243;
      tick(); data_wr = 0; cfg_wr = 0;
      chk("R4 flush beats push", int'(tx_level), 0);

      // R5 receive ready
      cfg(16'h4243);
      load(16'd10);
      bus_rx(8'h21); chk("R5 lvl1 no evt", int'(rx_ready_evt), 0);
      bus_rx(8'h22); chk("R5 lvl2 no evt", int'(rx_ready_evt), 0);
      bus_rx(8'h23); chk("R5 lvl3 evt", int'(rx_ready_evt), 1);
      tick();        chk("R5 single cycle", int'(rx_ready_evt), 0);
      bus_rx(8'h24); chk("R5 no repeat above thr", int'(rx_ready_evt), 0);

      // R6 receive draining
      cfg(16'h4243);
      load(16'd2);
      bus_rx(8'h31); chk("R6 one left no drain", int'(rx_drain_evt), 0);
      bus_rx(8'h32); chk("R6 drain at end", int'(rx_drain_evt), 1);
      chk("R6 no ready below thr", int'(rx_ready_evt), 0);
      tick();        chk("R6 drain single cycle", int'(rx_drain_evt), 0);

      // R9 counter saturates at zero
      bus_rx(8'h33);
      chk("R9 ready with count at 0", int'(rx_ready_evt), 1);
      chk("R9 no drain at thr", int'(rx_drain_evt), 0);
      cfg(16'h4203);
      bus_rx(8'h34);
      chk("R9 count stayed 0 (drain)", int'(rx_drain_evt), 1);

      // R9 zero-length transfer suppresses draining
      load(16'd0);
      cfg(16'h4203);
      bus_rx(8'h35);
      chk("R9 zero length rx level", int'(rx_level), 1);
      chk("R9 zero length no drain", int'(rx_drain_evt), 0);

      // R7 transmit ready
      cfg(16'h4243);
      load(16'd10);
      chk("R7 ready on load", int'(tx_ready_evt), 1);
      tick();
      chk("R7 single cycle", int'(tx_ready_evt), 0);
      for (int i = 0; i < 4; i++) sw_wr(8'(8'h40 + i));
      chk("R7 at thr no ready", int'(tx_ready_evt), 0);
      chk("R8 at thr no drain", int'(tx_drain_evt), 0);
      bus_pop();
      chk("R7 ready after pop below thr", int'(tx_ready_evt), 1);

      // R8 transmit draining
      for (int i = 0; i < 3; i++) sw_wr(8'(8'h50 + i));
      bus_pop(); bus_pop();
      chk("R8 level 4 no drain", int'(tx_drain_evt), 0);
      bus_pop();
      chk("R8 drain", int'(tx_drain_evt), 1);
      chk("R8 no ready with drain", int'(tx_ready_evt), 0);
      tick();
      chk("R8 drain single cycle", int'(tx_drain_evt), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule